// File: doc/BRIEF.md
# Operand Forwarding and Pipeline Interlock Controller

This controller sits beside the datapath of an in-order integer pipeline with five stages: fetch, decode with register read, execute, memory access and write-back. Each cycle it reads the register numbers, write enables and load and store flags that the datapath holds in its stage registers. From these it decides where each operand of the instruction in execute comes from. It sets the store-data source for a store in the memory stage and chooses the comparison operands for a branch in decode. It also decides when the front of the pipeline must hold and when a bubble or a no-op must be inserted.

Register 0 is hardwired to zero. The register file writes in the first half of a cycle and reads in the second, so a result in write-back is already visible to decode and needs no path to the branch comparator. Branches are tested and their targets computed in decode, so a taken branch costs one fetch slot, and the controller squashes that slot. The controller is purely combinational. Its clock and reset only time the embedded property checks. The datapath applies every select and hold on its next clock edge.

Top module: `hazard_ctl`

## Requirements
- R1: When the execute-stage register number of an operand (A from `ex_rs1`, B from `ex_rs2`) equals `mem_rd`, and the memory-stage instruction writes (`mem_we`=1) and is not a load, the operand select is 2'b10 (take the memory-stage ALU result).
- R2: When R1 does not apply and the operand number equals `wb_rd` with `wb_we`=1, the operand select is 2'b01 (take the write-back value, ALU result or load data). Otherwise the select is 2'b00 (register-file value).
- R3: When both the memory stage and the write-back stage write the operand's register, the memory-stage instruction, being younger, decides the select.
- R4: A producer whose destination is register 0, or whose write enable is 0, never causes forwarding, a stall or a store-data bypass.
- R5: If the execute stage holds a load (`ex_is_load`=1, `ex_we`=1) whose destination is a decode source used as an ALU input (`id_rs1` with `id_rs1_used`, or `id_rs2` with `id_rs2_used` when `id_is_store`=0), then `pc_stall`, `ifid_stall` and `idex_flush` are all 1 for that cycle and `ifid_flush` is 0.
- R6: A load followed directly by a store whose only dependence on it is the store data (`id_rs2`) causes no stall. When that store is in the memory stage (`mem_is_store`=1) and `mem_rs2` equals a writing `wb_rd`, `st_data_sel` is 1 (take write-back data); otherwise it is 0.
- R7: When the memory stage holds a load whose destination matches an execute operand, the operand select is 2'b00 even if write-back also matches, because the value does not yet exist; the store-data bypass of R6 supplies it one stage later.
- R8: A branch in decode (`id_is_branch`=1) stalls (same outputs as R5) when a used source matches a writing execute-stage instruction, or a memory-stage load. If a used source instead matches a writing memory-stage non-load, its branch select (`fwd_br_a` for `id_rs1`, `fwd_br_b` for `id_rs2`) is 1. A match only in write-back leaves the select at 0.
- R9: `ifid_flush` is 1 exactly when `id_br_taken` is 1 and no stall is raised in the same cycle. A taken indication during a stall is ignored.
- R10: With no dependence among the stages, every select, stall and flush output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that times the embedded checks |
| rst_n | input | 1 | Active-low reset, disables the checks |
| id_rs1 | input | 5 | Decode first source register |
| id_rs2 | input | 5 | Decode second source register |
| id_rs1_used | input | 1 | Decode instruction reads its first source |
| id_rs2_used | input | 1 | Decode instruction reads its second source |
| id_is_store | input | 1 | Decode instruction is a store (second source is store data) |
| id_is_branch | input | 1 | Decode instruction is a conditional branch |
| id_br_taken | input | 1 | Decode comparator reports a taken branch |
| ex_rs1 | input | 5 | Execute first source register |
| ex_rs2 | input | 5 | Execute second source register |
| ex_rd | input | 5 | Execute destination register |
| ex_we | input | 1 | Execute instruction writes a register |
| ex_is_load | input | 1 | Execute instruction is a load |
| mem_rs2 | input | 5 | Memory-stage store data register |
| mem_rd | input | 5 | Memory-stage destination register |
| mem_we | input | 1 | Memory-stage instruction writes a register |
| mem_is_load | input | 1 | Memory-stage instruction is a load |
| mem_is_store | input | 1 | Memory-stage instruction is a store |
| wb_rd | input | 5 | Write-back destination register |
| wb_we | input | 1 | Write-back instruction writes a register |
| fwd_a | output | 2 | Operand A source: 00 register, 01 write-back, 10 memory stage |
| fwd_b | output | 2 | Operand B source, same coding |
| fwd_br_a | output | 1 | Branch first operand from memory-stage ALU result |
| fwd_br_b | output | 1 | Branch second operand from memory-stage ALU result |
| st_data_sel | output | 1 | Store data from write-back value |
| pc_stall | output | 1 | Hold the program counter |
| ifid_stall | output | 1 | Hold the fetch/decode register |
| ifid_flush | output | 1 | Turn the fetch/decode register into a no-op |
| idex_flush | output | 1 | Load a bubble into the decode/execute register |

## Verification
The hardest situation to reach is the load whose consumer is a store: the same register pair must raise no interlock in decode, select the register path for operand B in execute while both later stages name that register, and then switch the store-data source in the memory stage. The bench steps one such instruction pair through three successive stage snapshots, driving the stage fields exactly as the pipeline would shift them. It also presents a taken branch together with a branch-operand interlock, so the flush must be dropped in favour of the hold.

// File: rtl/hazard_pkg.sv
package hazard_pkg;
  parameter int REG_AW = 5;
  typedef logic [REG_AW-1:0] reg_id_t;

  typedef enum logic [1:0] {
    SRC_REGFILE = 2'b00,
    SRC_WB      = 2'b01,
    SRC_MEMALU  = 2'b10
  } opnd_src_t;

  function automatic logic reg_hit(input reg_id_t src, input logic used,
                                   input reg_id_t dst, input logic wr);
    return used && wr && (dst != '0) && (src == dst);
  endfunction
endpackage

// File: rtl/hz_opnd_fwd.sv
module hz_opnd_fwd
  import hazard_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  reg_id_t   src,
  input  reg_id_t   mem_rd,
  input  logic      mem_we,
  input  logic      mem_is_load,
  input  reg_id_t   wb_rd,
  input  logic      wb_we,
  output opnd_src_t sel
);
  logic hit_mem, hit_wb;

  always_comb begin
    hit_mem = reg_hit(src, 1'b1, mem_rd, mem_we);
    hit_wb  = reg_hit(src, 1'b1, wb_rd, wb_we);
    if (hit_mem) begin
      // younger producer shadows write-back; a load has no value yet
      sel = mem_is_load ? SRC_REGFILE : SRC_MEMALU;
    end else if (hit_wb) begin
      sel = SRC_WB;
    end else begin
      sel = SRC_REGFILE;
    end
  end

  AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    sel != 2'b11); // R1
  AST_ZERO_SRC_NOFWD: assert property (@(posedge clk) disable iff (!rst_n)
    (src == '0) |-> (sel == SRC_REGFILE)); // R4
  AST_MEMALU_NEEDS_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SRC_MEMALU) |-> (mem_we && !mem_is_load && mem_rd == src)); // R1
  AST_LOAD_NO_MEMFWD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_is_load && mem_we && mem_rd == src) |-> (sel == SRC_REGFILE)); // R7
  AST_WB_YIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SRC_WB) |-> !(mem_we && mem_rd == src && src != '0)); // R3
endmodule

// File: rtl/hz_branch_ctl.sv
module hz_branch_ctl
  import hazard_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    id_is_branch,
  input  reg_id_t id_rs1,
  input  reg_id_t id_rs2,
  input  logic    id_rs1_used,
  input  logic    id_rs2_used,
  input  reg_id_t ex_rd,
  input  logic    ex_we,
  input  reg_id_t mem_rd,
  input  logic    mem_we,
  input  logic    mem_is_load,
  output logic    br_fwd_a,
  output logic    br_fwd_b,
  output logic    br_stall
);
  logic [1:0] ex_hit, mem_hit;
  reg_id_t    srcs [2];
  logic       used [2];

  assign srcs[0] = id_rs1;
  assign srcs[1] = id_rs2;
  assign used[0] = id_rs1_used;
  assign used[1] = id_rs2_used;

  for (genvar g = 0; g < 2; g++) begin : g_src
    always_comb begin
      ex_hit[g]  = id_is_branch && reg_hit(srcs[g], used[g], ex_rd, ex_we);
      mem_hit[g] = id_is_branch && reg_hit(srcs[g], used[g], mem_rd, mem_we);
    end
  end

  always_comb begin
    br_stall = (|ex_hit) || (mem_is_load && (|mem_hit));
    br_fwd_a = mem_hit[0] && !mem_is_load && !ex_hit[0];
    br_fwd_b = mem_hit[1] && !mem_is_load && !ex_hit[1];
  end

  AST_BR_FWD_NOT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (br_fwd_a || br_fwd_b) |-> !mem_is_load); // R8
  AST_BR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !id_is_branch |-> !(br_stall || br_fwd_a || br_fwd_b)); // R8
endmodule

// File: rtl/hz_stall_ctl.sv
module hz_stall_ctl
  import hazard_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  reg_id_t id_rs1,
  input  reg_id_t id_rs2,
  input  logic    id_rs1_used,
  input  logic    id_rs2_used,
  input  logic    id_is_store,
  input  logic    id_br_taken,
  input  reg_id_t ex_rd,
  input  logic    ex_we,
  input  logic    ex_is_load,
  input  logic    br_stall,
  output logic    pc_stall,
  output logic    ifid_stall,
  output logic    ifid_flush,
  output logic    idex_flush
);
  logic load_use, hold;

  always_comb begin
    load_use = ex_is_load &&
               (reg_hit(id_rs1, id_rs1_used, ex_rd, ex_we) ||
                reg_hit(id_rs2, id_rs2_used && !id_is_store, ex_rd, ex_we));
    hold       = load_use || br_stall;
    pc_stall   = hold;
    ifid_stall = hold;
    idex_flush = hold;
    ifid_flush = id_br_taken && !hold;
  end

  AST_HOLD_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_stall == ifid_stall) && (ifid_stall == idex_flush)); // R5
  AST_NO_FLUSH_ON_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    pc_stall |-> !ifid_flush); // R9
  AST_NO_REG0_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_rd == '0 && !br_stall) |-> !pc_stall); // R4
endmodule

// File: rtl/hz_store_fwd.sv
module hz_store_fwd
  import hazard_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    mem_is_store,
  input  reg_id_t mem_rs2,
  input  reg_id_t wb_rd,
  input  logic    wb_we,
  output logic    st_data_sel
);
  always_comb st_data_sel = reg_hit(mem_rs2, mem_is_store, wb_rd, wb_we);

  AST_ST_ONLY_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    st_data_sel |-> (mem_is_store && wb_we)); // R6
  AST_ST_NOT_R0: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_rd == '0) |-> !st_data_sel); // R4
endmodule

// File: rtl/hazard_ctl.sv
module hazard_ctl
  import hazard_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] id_rs1,
  input  logic [REG_AW-1:0] id_rs2,
  input  logic              id_rs1_used,
  input  logic              id_rs2_used,
  input  logic              id_is_store,
  input  logic              id_is_branch,
  input  logic              id_br_taken,
  input  logic [REG_AW-1:0] ex_rs1,
  input  logic [REG_AW-1:0] ex_rs2,
  input  logic [REG_AW-1:0] ex_rd,
  input  logic              ex_we,
  input  logic              ex_is_load,
  input  logic [REG_AW-1:0] mem_rs2,
  input  logic [REG_AW-1:0] mem_rd,
  input  logic              mem_we,
  input  logic              mem_is_load,
  input  logic              mem_is_store,
  input  logic [REG_AW-1:0] wb_rd,
  input  logic              wb_we,
  output logic [1:0]        fwd_a,
  output logic [1:0]        fwd_b,
  output logic              fwd_br_a,
  output logic              fwd_br_b,
  output logic              st_data_sel,
  output logic              pc_stall,
  output logic              ifid_stall,
  output logic              ifid_flush,
  output logic              idex_flush
);
  localparam int NUM_OPND = 2;

  reg_id_t   ex_src [NUM_OPND];
  opnd_src_t ex_sel [NUM_OPND];
  logic      br_stall;

  assign ex_src[0] = ex_rs1;
  assign ex_src[1] = ex_rs2;

  for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
    hz_opnd_fwd u_fwd (
      .clk(clk), .rst_n(rst_n), .src(ex_src[g]),
      .mem_rd(mem_rd), .mem_we(mem_we), .mem_is_load(mem_is_load),
      .wb_rd(wb_rd), .wb_we(wb_we), .sel(ex_sel[g])
    );
  end

  assign fwd_a = ex_sel[0];
  assign fwd_b = ex_sel[1];

  hz_branch_ctl u_br (
    .clk(clk), .rst_n(rst_n), .id_is_branch(id_is_branch),
    .id_rs1(id_rs1), .id_rs2(id_rs2),
    .id_rs1_used(id_rs1_used), .id_rs2_used(id_rs2_used),
    .ex_rd(ex_rd), .ex_we(ex_we),
    .mem_rd(mem_rd), .mem_we(mem_we), .mem_is_load(mem_is_load),
    .br_fwd_a(fwd_br_a), .br_fwd_b(fwd_br_b), .br_stall(br_stall)
  );

  hz_stall_ctl u_stall (
    .clk(clk), .rst_n(rst_n),
    .id_rs1(id_rs1), .id_rs2(id_rs2),
    .id_rs1_used(id_rs1_used), .id_rs2_used(id_rs2_used),
    .id_is_store(id_is_store), .id_br_taken(id_br_taken),
    .ex_rd(ex_rd), .ex_we(ex_we), .ex_is_load(ex_is_load),
    .br_stall(br_stall),
    .pc_stall(pc_stall), .ifid_stall(ifid_stall),
    .ifid_flush(ifid_flush), .idex_flush(idex_flush)
  );

  hz_store_fwd u_st (
    .clk(clk), .rst_n(rst_n), .mem_is_store(mem_is_store),
    .mem_rs2(mem_rs2), .wb_rd(wb_rd), .wb_we(wb_we),
    .st_data_sel(st_data_sel)
  );

  AST_QUIET_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ex_we && !mem_we && !wb_we && !id_br_taken) |->
      (fwd_a == 2'b00 && fwd_b == 2'b00 && !pc_stall && !ifid_flush && !st_data_sel)); // R10
  AST_WB_NOT_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we |-> !(fwd_br_a || fwd_br_b)); // R8
endmodule

// File: tb/tb_hazard_ctl.sv
module tb_hazard_ctl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rs2, mem_rd, wb_rd;
  logic id_rs1_used, id_rs2_used, id_is_store, id_is_branch, id_br_taken;
  logic ex_we, ex_is_load, mem_we, mem_is_load, mem_is_store, wb_we;
  logic [1:0] fwd_a, fwd_b;
  logic fwd_br_a, fwd_br_b, st_data_sel, pc_stall, ifid_stall, ifid_flush, idex_flush;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hazard_ctl dut (.*);

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle();
    {id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rs2, mem_rd, wb_rd} = '0;
    {id_rs1_used, id_rs2_used, id_is_store, id_is_branch, id_br_taken} = '0;
    {ex_we, ex_is_load, mem_we, mem_is_load, mem_is_store, wb_we} = '0;
  endtask

  task automatic settle();
    @(negedge clk); #1;
  endtask

  task automatic chk_hold(string req, int exp);
    chk(req, "pc_stall", pc_stall, exp);
    chk(req, "ifid_stall", ifid_stall, exp);
    chk(req, "idex_flush", idex_flush, exp);
  endtask

  task automatic t_quiet();
    idle(); id_rs1 = 5'd3; id_rs1_used = 1; ex_rs1 = 5'd4; ex_rs2 = 5'd5;
    ex_rd = 5'd6; mem_rd = 5'd7; wb_rd = 5'd8; ex_we = 1; mem_we = 1; wb_we = 1;
    settle();
    chk("R10", "fwd_a", fwd_a, 0); chk("R10", "fwd_b", fwd_b, 0);
    chk("R10", "ifid_flush", ifid_flush, 0); chk_hold("R10", 0);
  endtask

  task automatic t_memalu();
    idle(); ex_rs1 = 5'd9; ex_rs2 = 5'd9; mem_rd = 5'd9; mem_we = 1; settle();
    chk("R1", "fwd_a", fwd_a, 2); chk("R1", "fwd_b", fwd_b, 2);
  endtask

  task automatic t_wb();
    idle(); ex_rs1 = 5'd2; ex_rs2 = 5'd11; wb_rd = 5'd11; wb_we = 1; settle();
    chk("R2", "fwd_a", fwd_a, 0); chk("R2", "fwd_b", fwd_b, 1);
  endtask

  task automatic t_priority();
    idle(); ex_rs1 = 5'd12; mem_rd = 5'd12; mem_we = 1; wb_rd = 5'd12; wb_we = 1;
    settle(); chk("R3", "fwd_a", fwd_a, 2);
  endtask

  task automatic t_zero_rules();
    idle(); ex_rs1 = 5'd0; ex_rs2 = 5'd0; mem_rd = 5'd0; mem_we = 1; wb_rd = 5'd0; wb_we = 1;
    settle(); chk("R4", "fwd_a r0", fwd_a, 0); chk("R4", "fwd_b r0", fwd_b, 0);
    idle(); ex_rs1 = 5'd13; mem_rd = 5'd13; mem_we = 0; settle();
    chk("R4", "fwd_a we0", fwd_a, 0);
    idle(); id_rs1 = 5'd0; id_rs1_used = 1; ex_rd = 5'd0; ex_we = 1; ex_is_load = 1;
    settle(); chk_hold("R4", 0);
    idle(); mem_is_store = 1; mem_rs2 = 5'd0; wb_rd = 5'd0; wb_we = 1; settle();
    chk("R4", "st_data_sel r0", st_data_sel, 0);
  endtask

  task automatic t_load_use();
    idle(); id_rs2 = 5'd14; id_rs2_used = 1; ex_rd = 5'd14; ex_we = 1; ex_is_load = 1;
    settle(); chk_hold("R5", 1); chk("R5", "ifid_flush", ifid_flush, 0);
    idle(); id_rs1 = 5'd14; id_rs1_used = 1; id_is_store = 1;
    ex_rd = 5'd14; ex_we = 1; ex_is_load = 1; settle();
    chk_hold("R5", 1);
  endtask

  // lw r15 ; sw r15 stepped through three stage snapshots
  task automatic t_load_store();
    idle(); id_is_store = 1; id_rs1 = 5'd1; id_rs1_used = 1; id_rs2 = 5'd15; id_rs2_used = 1;
    ex_rd = 5'd15; ex_we = 1; ex_is_load = 1; settle();
    chk_hold("R6", 0);
    idle(); ex_rs1 = 5'd1; ex_rs2 = 5'd15; mem_rd = 5'd15; mem_we = 1; mem_is_load = 1;
    wb_rd = 5'd15; wb_we = 1; settle();
    chk("R7", "fwd_b", fwd_b, 0); chk("R7", "fwd_a", fwd_a, 0);
    idle(); mem_is_store = 1; mem_rs2 = 5'd15; wb_rd = 5'd15; wb_we = 1; settle();
    chk("R6", "st_data_sel", st_data_sel, 1);
    wb_rd = 5'd16; settle(); chk("R6", "st_data_sel mismatch", st_data_sel, 0);
  endtask

  task automatic t_branch();
    idle(); id_is_branch = 1; id_rs1 = 5'd17; id_rs1_used = 1; ex_rd = 5'd17; ex_we = 1;
    settle(); chk_hold("R8", 1);
    idle(); id_is_branch = 1; id_rs2 = 5'd18; id_rs2_used = 1;
    mem_rd = 5'd18; mem_we = 1; mem_is_load = 1; settle();
    chk_hold("R8", 1); chk("R8", "fwd_br_b load", fwd_br_b, 0);
    idle(); id_is_branch = 1; id_rs2 = 5'd19; id_rs2_used = 1; mem_rd = 5'd19; mem_we = 1;
    settle(); chk_hold("R8", 0); chk("R8", "fwd_br_b", fwd_br_b, 1); chk("R8", "fwd_br_a", fwd_br_a, 0);
    idle(); id_is_branch = 1; id_rs1 = 5'd20; id_rs1_used = 1; wb_rd = 5'd20; wb_we = 1;
    settle(); chk("R8", "fwd_br_a wb", fwd_br_a, 0); chk_hold("R8", 0);
  endtask

  task automatic t_taken();
    idle(); id_is_branch = 1; id_br_taken = 1; settle();
    chk("R9", "ifid_flush", ifid_flush, 1); chk_hold("R9", 0);
    idle(); id_is_branch = 1; id_br_taken = 1; id_rs1 = 5'd21; id_rs1_used = 1;
    ex_rd = 5'd21; ex_we = 1; settle();
    chk("R9", "ifid_flush in hold", ifid_flush, 0); chk_hold("R9", 1);
  endtask

  initial begin
    #20000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    #1;
    chk("R10", "reset fwd_a", fwd_a, 0);
    chk("R10", "reset pc_stall", pc_stall, 0);
    rst_n = 1'b1;
    t_quiet(); t_memalu(); t_wb(); t_priority(); t_zero_rules();
    t_load_use(); t_load_store(); t_branch(); t_taken();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule